// File: doc/BRIEF.md
# Vectored interrupt controller

This block gathers 32 interrupt sources into a normal interrupt line and a fast interrupt line, and gives the processor a handler address for the most urgent normal request. Each source is the OR of a level-sensitive hardware input and a bit that software can raise. An enable mask gates every source. A per-source route bit then sends the request either to the fast line or to the normal line. The controller sits behind a simple register bus with a byte address, write data, write and read strobes, and read data. Read data is combinational from the address.

Sixteen priority slots each name one source number and hold a handler address. Slot 0 is the most urgent. A normal request that no enabled slot claims falls back to a default handler address, which has the lowest priority. Reading the current-vector register returns the winning address and marks that level as in service. While a level is in service, only more urgent slots can raise the normal line. Any write to the same register ends service of the most recently claimed level, so handlers can nest.

Top module: `vic_ctrl`

## Requirements
- R1: After reset every register reads 0, and both interrupt outputs stay low until software enables a source.
- R2: Writing to the enable-set register (0x010) sets the enable bits written as 1. Writing to the enable-clear register (0x014) clears the bits written as 1. Zero bits leave the mask unchanged. The mask reads back at 0x010.
- R3: The software-request pair works the same way: set at 0x018 (which also reads back the bits) and clear at 0x01C. The raw status at 0x008 reads the hardware inputs ORed with the software bits, and bit n belongs to source n.
- R4: The route register at 0x00C sends an enabled active source to the normal path when its bit is 0. The normal status at 0x000 reads raw & enable & ~route. irq_o is high only when a normal request is eligible under the in-service rule of R8.
- R5: A route bit of 1 sends the enabled source to the fast path. The fast status at 0x004 reads raw & enable & route. fiq_o is high whenever that value is non-zero, and fiq_o takes no part in the priority logic.
- R6: Slot n has a control register at 0x200+4n and an address register at 0x100+4n. In the control register, bit 5 is the enable and bits 4:0 are the source number. Reading 0x030 returns the address of the lowest-numbered enabled slot whose source has a pending normal request and is allowed by R8. A disabled slot never matches.
- R7: When no slot matches, a read of 0x030 returns the default address register at 0x034. This holds both when a pending normal request belongs to no enabled slot and when nothing is pending.
- R8: A read of 0x030 that finds an eligible request marks its level as in service. Slot levels are 0 to 15, and the default level sits below slot 15. While a level is in service, only slots with a smaller number may raise irq_o or win a vector read. A read that finds nothing eligible marks nothing.
- R9: Any write to 0x030 ends service of the most recently claimed level. The previously claimed level, if any, becomes the limit again.
- R10: The identification bytes at 0xFE0, 0xFE4, 0xFE8 and 0xFEC read 0x41, 0x5E, 0x0A and 0x00 in bits 7:0, with upper bits zero. Taken little-endian they form 0x000A5E41, whose vendor field (bits 19:12) is 0xA5. Writes to them have no effect.
- R11: The protection register (0x020) and the test-control register (0x300) each store bit 0 and read it back. Writing 0 to test-control keeps normal operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Level-sensitive hardware interrupt sources |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; on 0x030 it claims the current level |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Every cycle, the assertions check these properties: both outputs are quiet after reset, irq_o never rises without an active source, an enable-set write leaves its bits set, and a vector read that finds work marks a level in service. They also check that each end-of-service write retires exactly one level and that identification reads carry no bits above the byte. The bench's scenarios are needed for the behaviour that depends on sequence and programming: the slot ordering, the default fallback, nested claims above an in-service level, and the unwinding of the nest step by step. They also cover the route split between the two outputs and the fact that a read finding nothing leaves no stale level behind.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int NSRC   = 32;
    localparam int SRC_W  = $clog2(NSRC);
    localparam int NSLOT  = 16;
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int NLVL   = NSLOT + 1;
    localparam int ADDR_W = 12;
    localparam int DW     = 32;

    localparam logic [DW-1:0] CELL_ID = 32'h000A_5E41;

    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t A_IRQ_STAT   = 12'h000;
    localparam addr_t A_FIQ_STAT   = 12'h004;
    localparam addr_t A_RAW        = 12'h008;
    localparam addr_t A_SEL        = 12'h00C;
    localparam addr_t A_EN_SET     = 12'h010;
    localparam addr_t A_EN_CLR     = 12'h014;
    localparam addr_t A_SW_SET     = 12'h018;
    localparam addr_t A_SW_CLR     = 12'h01C;
    localparam addr_t A_PROT       = 12'h020;
    localparam addr_t A_CUR_VEC    = 12'h030;
    localparam addr_t A_DEF_VEC    = 12'h034;
    localparam addr_t A_VADDR_BASE = 12'h100;
    localparam addr_t A_VCTL_BASE  = 12'h200;
    localparam addr_t A_TEST       = 12'h300;
    localparam addr_t A_ID_BASE    = 12'hFE0;

    // Slot control word: enable above the source number.
    typedef struct packed {
        logic             en;
        logic [SRC_W-1:0] src;
    } slot_ctl_t;

    // True when address a falls in the aligned per-slot window at base.
    function automatic logic in_window(addr_t a, addr_t base);
        return a[ADDR_W-1:SLOT_W+2] == base[ADDR_W-1:SLOT_W+2];
    endfunction

    function automatic logic [SLOT_W-1:0] slot_idx(addr_t a);
        return a[SLOT_W+1:2];
    endfunction

    // Retire the most urgent in-service level (lowest set bit).
    function automatic logic [NLVL-1:0] drop_lowest(logic [NLVL-1:0] v);
        return v & (v - NLVL'(1));
    endfunction

endpackage

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  addr_t                     addr,
    input  logic [DW-1:0]             wdata,
    input  logic                      wr,
    output logic [NSRC-1:0]           en_q,
    output logic [NSRC-1:0]           soft_q,
    output logic [NSRC-1:0]           sel_q,
    output logic [DW-1:0]             defvec_q,
    output logic [NSLOT-1:0][DW-1:0]  vaddr_q,
    output slot_ctl_t [NSLOT-1:0]     vctl_q,
    output logic                      prot_q,
    output logic                      test_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            soft_q   <= '0;
            sel_q    <= '0;
            defvec_q <= '0;
            prot_q   <= 1'b0;
            test_q   <= 1'b0;
        end else if (wr) begin
            case (addr)
                A_EN_SET:  en_q     <= en_q | wdata[NSRC-1:0];
                A_EN_CLR:  en_q     <= en_q & ~wdata[NSRC-1:0];
                A_SW_SET:  soft_q   <= soft_q | wdata[NSRC-1:0];
                A_SW_CLR:  soft_q   <= soft_q & ~wdata[NSRC-1:0];
                A_SEL:     sel_q    <= wdata[NSRC-1:0];
                A_DEF_VEC: defvec_q <= wdata;
                A_PROT:    prot_q   <= wdata[0];
                A_TEST:    test_q   <= wdata[0];
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic [DW-1:0] va_r;
        slot_ctl_t     ctl_r;
        logic          hit_va;
        logic          hit_ctl;

        assign hit_va  = wr && in_window(addr, A_VADDR_BASE) && (slot_idx(addr) == SLOT_W'(g));
        assign hit_ctl = wr && in_window(addr, A_VCTL_BASE)  && (slot_idx(addr) == SLOT_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                va_r  <= '0;
                ctl_r <= '0;
            end else begin
                if (hit_va)  va_r  <= wdata;
                if (hit_ctl) ctl_r <= slot_ctl_t'(wdata[SRC_W:0]);
            end
        end

        assign vaddr_q[g] = va_r;
        assign vctl_q[g]  = ctl_r;
    end

endmodule

// File: rtl/vic_prio.sv
module vic_prio
    import vic_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NSRC-1:0]           irq_req,
    input  slot_ctl_t [NSLOT-1:0]     vctl,
    input  logic [NSLOT-1:0][DW-1:0]  vaddr,
    input  logic [DW-1:0]             defvec,
    input  logic                      claim,
    input  logic                      finish,
    output logic                      irq_o,
    output logic [DW-1:0]             vec_addr,
    output logic [NLVL-1:0]           svc_q
);

    logic [NSLOT-1:0]  hit;
    logic [NSLOT-1:0]  allow;
    logic [NSLOT-1:0]  ok_hit;
    logic [NSRC-1:0]   assigned;
    logic [SLOT_W-1:0] win;
    logic              any_hit;
    logic              def_pend;

    // A slot is eligible when no level at or above its urgency is in service.
    for (genvar g = 0; g < NSLOT; g++) begin : g_lvl
        assign hit[g] = vctl[g].en & irq_req[vctl[g].src];
        if (g == 0) begin : g_first
            assign allow[g] = ~svc_q[0];
        end else begin : g_rest
            assign allow[g] = allow[g-1] & ~svc_q[g];
        end
    end

    always_comb begin
        assigned = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (vctl[i].en) assigned[vctl[i].src] = 1'b1;
        end
    end

    assign ok_hit   = hit & allow;
    assign any_hit  = |ok_hit;
    assign def_pend = (|(irq_req & ~assigned)) & ~(|svc_q);

    always_comb begin
        win = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (ok_hit[i]) win = SLOT_W'(i);
        end
    end

    assign irq_o    = any_hit | def_pend;
    assign vec_addr = any_hit ? vaddr[win] : defvec;

    always_ff @(posedge clk) begin
        if (rst) begin
            svc_q <= '0;
        end else if (finish) begin
            svc_q <= drop_lowest(svc_q);
        end else if (claim) begin
            if (any_hit)       svc_q <= svc_q | (NLVL'(1) << win);
            else if (def_pend) svc_q[NSLOT] <= 1'b1;
        end
    end

endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [31:0]   src_i,
    input  logic [11:0]   bus_addr,
    input  logic [31:0]   bus_wdata,
    input  logic          bus_wr,
    input  logic          bus_rd,
    output logic [31:0]   bus_rdata,
    output logic          irq_o,
    output logic          fiq_o
);

    logic [NSRC-1:0]          en_q;
    logic [NSRC-1:0]          soft_q;
    logic [NSRC-1:0]          sel_q;
    logic [DW-1:0]            defvec_q;
    logic [NSLOT-1:0][DW-1:0] vaddr_q;
    slot_ctl_t [NSLOT-1:0]    vctl_q;
    logic                     prot_q;
    logic                     test_q;
    logic [NSRC-1:0]          raw;
    logic [NSRC-1:0]          irq_req;
    logic [NSRC-1:0]          fiq_req;
    logic [DW-1:0]            vec_addr;
    logic [NLVL-1:0]          svc_q;
    logic                     claim;
    logic                     finish;

    vic_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .wr       (bus_wr),
        .en_q     (en_q),
        .soft_q   (soft_q),
        .sel_q    (sel_q),
        .defvec_q (defvec_q),
        .vaddr_q  (vaddr_q),
        .vctl_q   (vctl_q),
        .prot_q   (prot_q),
        .test_q   (test_q)
    );

    assign raw     = src_i | soft_q;
    assign irq_req = raw & en_q & ~sel_q;
    assign fiq_req = raw & en_q & sel_q;
    assign fiq_o   = |fiq_req;

    assign claim  = bus_rd & ~bus_wr & (bus_addr == A_CUR_VEC);
    assign finish = bus_wr & (bus_addr == A_CUR_VEC);

    vic_prio u_prio (
        .clk      (clk),
        .rst      (rst),
        .irq_req  (irq_req),
        .vctl     (vctl_q),
        .vaddr    (vaddr_q),
        .defvec   (defvec_q),
        .claim    (claim),
        .finish   (finish),
        .irq_o    (irq_o),
        .vec_addr (vec_addr),
        .svc_q    (svc_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (in_window(bus_addr, A_VADDR_BASE)) begin
            bus_rdata = vaddr_q[slot_idx(bus_addr)];
        end else if (in_window(bus_addr, A_VCTL_BASE)) begin
            bus_rdata = 32'(vctl_q[slot_idx(bus_addr)]);
        end else if (bus_addr[ADDR_W-1:4] == A_ID_BASE[ADDR_W-1:4]) begin
            bus_rdata = {24'b0, CELL_ID[{bus_addr[3:2], 3'b000} +: 8]};
        end else begin
            case (bus_addr)
                A_IRQ_STAT: bus_rdata = irq_req;
                A_FIQ_STAT: bus_rdata = fiq_req;
                A_RAW:      bus_rdata = raw;
                A_SEL:      bus_rdata = sel_q;
                A_EN_SET:   bus_rdata = en_q;
                A_SW_SET:   bus_rdata = soft_q;
                A_PROT:     bus_rdata = {31'b0, prot_q};
                A_CUR_VEC:  bus_rdata = vec_addr;
                A_DEF_VEC:  bus_rdata = defvec_q;
                A_TEST:     bus_rdata = {31'b0, test_q};
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk
    import vic_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [11:0]     bus_addr,
    input logic [31:0]     bus_wdata,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic [31:0]     bus_rdata,
    input logic [31:0]     src_i,
    input logic            irq_o,
    input logic            fiq_o,
    input logic [NSRC-1:0] en_q,
    input logic [NSRC-1:0] soft_q,
    input logic [NLVL-1:0] svc_q
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!irq_o && !fiq_o));

    // R2
    enable_set_sticks_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_EN_SET) |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

    // R4
    irq_needs_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (|(src_i | soft_q)));

    // R8
    claim_marks_level_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == A_CUR_VEC && irq_o) |=> (svc_q != '0));

    // R9
    finish_retires_one_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CUR_VEC && svc_q != '0)
            |=> ($countones(svc_q) == $countones($past(svc_q)) - 1));

    // R10
    id_byte_only_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[11:4] == A_ID_BASE[11:4]) |-> (bus_rdata[31:8] == 24'b0));

endmodule

bind vic_ctrl vic_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .src_i     (src_i),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .en_q      (en_q),
    .soft_q    (soft_q),
    .svc_q     (svc_q)
);

// File: tb/vic_ctrl_test.sv
`timescale 1ns/1ps
module vic_ctrl_test;
    import vic_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_i = '0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    wire  [31:0] rdata;
    wire         irq_o;
    wire         fiq_o;

    int n_chk = 0;
    int n_err = 0;
    bit live  = 1'b0;

    always #2 clk = ~clk;

    vic_ctrl uut (
        .clk(clk), .rst(rst), .src_i(src_i),
        .bus_addr(addr), .bus_wdata(wdata), .bus_wr(wr), .bus_rd(rd),
        .bus_rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    // Behavioural reference state
    logic [31:0] m_en = '0, m_soft = '0, m_sel = '0, m_def = '0;
    logic [31:0] m_va  [16];
    logic [5:0]  m_ctl [16];
    logic        m_prot = 1'b0, m_test = 1'b0;
    int          stk[$];

    function automatic logic [31:0] m_irqreq();
        return (src_i | m_soft) & m_en & ~m_sel;
    endfunction

    // -1: nothing eligible, 0..15: slot, 16: default
    function automatic int m_win();
        logic [31:0] rq  = m_irqreq();
        logic [31:0] asg = '0;
        int lv = (stk.size() > 0) ? stk[stk.size()-1] : 17;
        for (int n = 0; n < 16; n++) if (m_ctl[n][5]) asg[m_ctl[n][4:0]] = 1'b1;
        for (int n = 0; n < 16; n++)
            if (n < lv && m_ctl[n][5] && rq[m_ctl[n][4:0]]) return n;
        if (lv == 17 && (rq & ~asg) != 0) return 16;
        return -1;
    endfunction

    function automatic logic [31:0] m_read(logic [11:0] a);
        int w;
        if (a >= 12'h100 && a < 12'h140) return m_va[a[5:2]];
        if (a >= 12'h200 && a < 12'h240) return {26'b0, m_ctl[a[5:2]]};
        case (a)
            12'h000: return m_irqreq();
            12'h004: return (src_i | m_soft) & m_en & m_sel;
            12'h008: return src_i | m_soft;
            12'h00C: return m_sel;
            12'h010: return m_en;
            12'h018: return m_soft;
            12'h020: return {31'b0, m_prot};
            12'h030: begin
                w = m_win();
                return (w >= 0 && w < 16) ? m_va[w] : m_def;
            end
            12'h034: return m_def;
            12'h300: return {31'b0, m_test};
            12'hFE0: return 32'h41;
            12'hFE4: return 32'h5E;
            12'hFE8: return 32'h0A;
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_write(logic [11:0] a, logic [31:0] d);
        if (a >= 12'h100 && a < 12'h140) m_va[a[5:2]] = d;
        else if (a >= 12'h200 && a < 12'h240) m_ctl[a[5:2]] = d[5:0];
        else case (a)
            12'h010: m_en   = m_en | d;
            12'h014: m_en   = m_en & ~d;
            12'h018: m_soft = m_soft | d;
            12'h01C: m_soft = m_soft & ~d;
            12'h00C: m_sel  = d;
            12'h034: m_def  = d;
            12'h020: m_prot = d[0];
            12'h300: m_test = d[0];
            12'h030: if (stk.size() > 0) void'(stk.pop_back());
            default: ;
        endcase
    endtask

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Per-cycle comparison of both outputs against the model
    always @(negedge clk) begin
        if (live) begin
            #1;
            check("R4/R8 irq_o per cycle", {31'b0, irq_o}, {31'b0, (m_win() >= 0)});
            check("R5 fiq_o per cycle", {31'b0, fiq_o},
                  {31'b0, (((src_i | m_soft) & m_en & m_sel) != 0)});
        end
    end

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        #1;
        wr = 1'b0;
        m_write(a, d);
    endtask

    task automatic bus_read(logic [11:0] a, logic [31:0] lit, bit use_lit, string tag);
        int w;
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1;
        check(tag, rdata, m_read(a));
        if (use_lit) check({tag, " (fixed)"}, rdata, lit);
        w = m_win();
        @(posedge clk);
        #1;
        rd = 1'b0;
        if (a == 12'h030 && w >= 0) stk.push_back(w);
    endtask

    task automatic pin_check(string tag, logic got_irq, logic exp_irq);
        @(negedge clk);
        #1;
        check(tag, {31'b0, irq_o}, {31'b0, exp_irq});
    endtask

    task automatic set_src(logic [31:0] v);
        @(negedge clk);
        src_i = v;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #400000;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int n = 0; n < 16; n++) begin m_va[n] = '0; m_ctl[n] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 irq_o after reset", {31'b0, irq_o}, 32'h0);
        check("R1 fiq_o after reset", {31'b0, fiq_o}, 32'h0);
        bus_read(12'h010, 32'h0, 1, "R1 enable reset");
        bus_read(12'h00C, 32'h0, 1, "R1 route reset");
        bus_read(12'h204, 32'h0, 1, "R1 slot control reset");
        bus_read(12'h034, 32'h0, 1, "R1 default vector reset");
        live = 1'b1;

        // R2 write-one set / clear
        bus_write(12'h010, 32'hF0);
        bus_write(12'h010, 32'h03);
        bus_read(12'h010, 32'hF3, 1, "R2 enable set");
        bus_write(12'h014, 32'h30);
        bus_read(12'h010, 32'hC3, 1, "R2 enable clear");

        // R3 software requests merged with hardware
        set_src(32'h100);
        bus_write(12'h018, 32'h80);
        bus_read(12'h008, 32'h180, 1, "R3 raw status");
        bus_write(12'h018, 32'h400);
        bus_write(12'h01C, 32'h400);
        bus_read(12'h018, 32'h80, 1, "R3 soft clear");

        // R4 / R5 routing
        bus_write(12'h00C, 32'h80);
        bus_write(12'h010, 32'h100);
        bus_read(12'h000, 32'h100, 1, "R4 normal status");
        bus_read(12'h004, 32'h80, 1, "R5 fast status");
        @(negedge clk); #1;
        check("R5 fiq_o high", {31'b0, fiq_o}, 32'h1);

        // R6 / R8 / R9 slots and nesting
        bus_write(12'h034, 32'hD0D0);
        bus_write(12'h20C, 32'h28);
        bus_write(12'h10C, 32'h3000);
        bus_write(12'h204, 32'h29);
        bus_write(12'h104, 32'h1000);
        bus_read(12'h030, 32'h3000, 1, "R6 slot 3 vector");
        pin_check("R8 irq masked at own level", irq_o, 1'b0);
        set_src(32'h300);
        bus_write(12'h010, 32'h200);
        pin_check("R8 higher slot preempts", irq_o, 1'b1);
        bus_read(12'h030, 32'h1000, 1, "R6 slot 1 vector");
        pin_check("R8 nested level masks", irq_o, 1'b0);
        bus_write(12'h030, 32'h0);
        pin_check("R9 pop returns to level 3", irq_o, 1'b1);
        set_src(32'h100);
        bus_write(12'h030, 32'h0);
        pin_check("R9 pop to idle", irq_o, 1'b1);
        bus_read(12'h030, 32'h3000, 1, "R6 reclaim slot 3");
        bus_write(12'h030, 32'h0);

        // R7 default vector
        bus_write(12'h014, 32'h300);
        bus_write(12'h018, 32'h4);
        bus_write(12'h010, 32'h4);
        bus_read(12'h030, 32'hD0D0, 1, "R7 unassigned source");
        pin_check("R8 default in service", irq_o, 1'b0);
        bus_write(12'h030, 32'h0);
        bus_write(12'h200, 32'h02);
        bus_read(12'h030, 32'hD0D0, 1, "R6 disabled slot ignored");
        bus_write(12'h100, 32'h0A0A);
        bus_write(12'h200, 32'h22);
        pin_check("R8 slot above default", irq_o, 1'b1);
        bus_read(12'h030, 32'h0A0A, 1, "R8 nest over default");
        bus_write(12'h030, 32'h0);
        bus_write(12'h030, 32'h0);

        bus_write(12'h01C, 32'h4);
        bus_write(12'h014, 32'hFFFF_FFFF);
        bus_read(12'h030, 32'hD0D0, 1, "R7 nothing pending");
        bus_write(12'h010, 32'h4);
        bus_write(12'h018, 32'h4);
        pin_check("R8 empty read marks nothing", irq_o, 1'b1);

        // R10 identification
        bus_read(12'hFE0, 32'h41, 1, "R10 id byte 0");
        bus_read(12'hFE4, 32'h5E, 1, "R10 id byte 1");
        bus_read(12'hFE8, 32'h0A, 1, "R10 id byte 2");
        bus_read(12'hFEC, 32'h00, 1, "R10 id byte 3");
        bus_write(12'hFE0, 32'hFF);
        bus_read(12'hFE0, 32'h41, 1, "R10 id write ignored");

        // R11 protection and test control
        bus_write(12'h020, 32'h1);
        bus_read(12'h020, 32'h1, 1, "R11 protect");
        bus_write(12'h300, 32'h1);
        bus_read(12'h300, 32'h1, 1, "R11 test set");
        bus_write(12'h300, 32'h0);
        bus_read(12'h300, 32'h0, 1, "R11 test normal");

        // R2 clear everything
        bus_write(12'h014, 32'hFFFF_FFFF);
        pin_check("R2 all cleared irq", irq_o, 1'b0);
        @(negedge clk); #1;
        check("R2 all cleared fiq", {31'b0, fiq_o}, 32'h0);

        live = 1'b0;
        finish_run();
    end

endmodule